// File: doc/BRIEF.md
# System Segment Selector Loader

This block carries out the load of one of two system segment registers, the local descriptor table register or the task register, from a 16-bit selector. A request carries the target register, the selector, the current privilege level and whether the processor is in protected mode. The block checks these in a fixed order. It fetches the 8-byte descriptor from the global descriptor table as two 32-bit reads and validates the descriptor type and present bit. It then either loads the selector, base, byte-granular limit and attribute bits into the target register, or ends with a fault vector and an error code.

A successful task register load first writes the descriptor's access byte back to memory with the busy bit set. The register is updated in the same cycle that the write is accepted. A short-limit warning accompanies a successful load and does not stop it. The global descriptor table base and limit are sampled when a request is accepted.

Back-pressure: a request transfers on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The block holds `mem_rd_valid` and `mem_rd_addr` until `mem_rd_ready`. After that it waits for exactly one `mem_rsp_valid` beat, and it is always ready to take that beat. `mem_wr_valid`, address and data are held until `mem_wr_ready`. The completion status on `done_o` is a plain one-cycle pulse.

Top module: `sysseg_loader`

## Requirements
- R1: After reset both registers read invalid with selector, base, limit and attributes zero, `req_ready` is high and `done_o` is low.
- R2: A request with `req_prot` low ends with fault vector 6 (undefined opcode) and code 0, makes no memory access, and takes precedence over every other check.
- R3: In protected mode a privilege level other than 0 ends with fault vector 13 (general protection) and code 0. This check comes before the null-selector check.
- R4: A null selector (bits 15:2 all zero) raises no fault, makes no memory access and clears the target's valid bit. The local table register keeps the given selector value. The task register selector becomes 0.
- R5: A local table load whose selector has bit 2 (table indicator) set ends with vector 13 and error code `sel & 0xFFFC`.
- R6: If `index*8+7` (index = selector bits 15:3) exceeds the table limit, the load ends with vector 13 and code `sel & 0xFFFC` and no read is made. The last entry that fits is accepted.
- R7: The low dword is read at `base + index*8`, then the high dword at that address plus 4. The 5-bit type `{S,type}` sits in high-dword bits 12:8. A local table load needs 0x02; a task register load needs 0x01 or 0x09. Any other type ends with vector 13 and code `sel & 0xFFFC`.
- R8: A matching type with the present bit (high bit 15) clear ends with vector 11 (not present) and code `sel & 0xFFFC`.
- R9: A successful load sets valid and stores the selector as given. It stores base `{hi[31:24],hi[7:0],lo[31:16]}`, attributes `hi[23:8]` and the limit, and signals vector 0.
- R10: The 20-bit limit `{hi[19:16],lo[15:0]}` is used as is when high bit 23 is clear. When that bit is set, it is shifted left 12 and ORed with 0xFFF.
- R11: A successful task register load writes byte `hi[15:8] | 0x02` to `base + index*8 + 5`. A later load of the same, now busy, descriptor ends with vector 13.
- R12: `warn_o` accompanies success when the scaled limit is below 43 for type 0x01, below 103 for type 0x09, or below 7 for a local table.
- R13: The handshake rules above hold under memory back-pressure. `done_o` is a single-cycle pulse and fault error codes always have bits 1:0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_tr | input | 1 | Target: 1 task register, 0 local table register |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_prot | input | 1 | Protected mode |
| gdt_base | input | AW | Descriptor table base address |
| gdt_limit | input | 16 | Descriptor table limit (last valid byte offset) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Read byte address (dword) |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read data, little endian |
| mem_wr_valid | output | 1 | Byte write valid |
| mem_wr_ready | input | 1 | Byte write accepted |
| mem_wr_addr | output | AW | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_vec_o | output | 5 | 0 none, 6, 11 or 13 |
| fault_code_o | output | 16 | Fault error code |
| warn_o | output | 1 | Short-limit warning on success |
| ldtr_sel_o | output | 16 | Local table register selector |
| ldtr_base_o | output | 32 | Local table register base |
| ldtr_limit_o | output | 32 | Local table register byte limit |
| ldtr_attr_o | output | 16 | Local table register attributes |
| ldtr_valid_o | output | 1 | Local table register valid |
| tr_sel_o | output | 16 | Task register selector |
| tr_base_o | output | 32 | Task register base |
| tr_limit_o | output | 32 | Task register byte limit |
| tr_attr_o | output | 16 | Task register attributes |
| tr_valid_o | output | 1 | Task register valid |

## Verification
The assertions watch on every cycle that a read request holds its address under back-pressure. They also check that real-mode requests never touch memory, that only a task register load writes and that its byte carries the busy bit, that a fault leaves both registers unchanged, and that every completion is idle-aligned with word-aligned error codes. The check ordering, the decoded base and scaled limit, the selector kept or zeroed on a null load, the warning thresholds and the busy descriptor being refused on reload depend on the descriptor contents. Only the bench scenarios, with a memory model holding known descriptors, can show them.

// File: rtl/sysseg_pkg.sv
package sysseg_pkg;
  typedef enum logic [4:0] {
    FV_NONE = 5'd0,
    FV_UD   = 5'd6,
    FV_NP   = 5'd11,
    FV_GP   = 5'd13
  } fault_vec_e;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] limit;
    logic [15:0] attr;
    logic        valid;
  } sysreg_t;

  localparam logic [4:0] TYP_LDT   = 5'h02;
  localparam logic [4:0] TYP_TSS16 = 5'h01;
  localparam logic [4:0] TYP_TSS32 = 5'h09;
  localparam int unsigned MIN_LDT   = 7;
  localparam int unsigned MIN_TSS16 = 43;
  localparam int unsigned MIN_TSS32 = 103;
endpackage

// File: rtl/sysseg_desc_check.sv
module sysseg_desc_check
  import sysseg_pkg::*;
(
  input  logic [31:0] dlo,
  input  logic [31:0] dhi,
  input  logic        is_tr,
  output logic        type_ok,
  output logic        present,
  output logic [31:0] base,
  output logic [31:0] limit,
  output logic [15:0] attr,
  output logic        warn,
  output logic [7:0]  busy_byte
);
  logic [4:0]  typ;
  logic [19:0] raw_lim;

  assign typ       = dhi[12:8];
  assign present   = dhi[15];
  assign raw_lim   = {dhi[19:16], dlo[15:0]};
  assign base      = {dhi[31:24], dhi[7:0], dlo[31:16]};
  assign attr      = dhi[23:8];
  assign limit     = dhi[23] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
  assign busy_byte = dhi[15:8] | 8'h02;

  always_comb begin
    if (is_tr) type_ok = (typ == TYP_TSS16) || (typ == TYP_TSS32);
    else       type_ok = (typ == TYP_LDT);
  end

  always_comb begin
    if (!is_tr)                 warn = limit < MIN_LDT;
    else if (typ == TYP_TSS16)  warn = limit < MIN_TSS16;
    else                        warn = limit < MIN_TSS32;
  end
endmodule

// File: rtl/sysseg_reg.sv
module sysseg_reg
  import sysseg_pkg::*;
#(
  parameter bit KEEP_SEL_ON_NULL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        clear,
  input  logic [15:0] sel,
  input  logic [31:0] base,
  input  logic [31:0] limit,
  input  logic [15:0] attr,
  output sysreg_t     q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clear) begin
      q.sel   <= KEEP_SEL_ON_NULL ? sel : 16'h0000;
      q.valid <= 1'b0;
    end else if (load) begin
      q.sel   <= sel;
      q.base  <= base;
      q.limit <= limit;
      q.attr  <= attr;
      q.valid <= 1'b1;
    end
  end

  assert_clear_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !q.valid);
endmodule

// File: rtl/sysseg_loader.sv
module sysseg_loader
  import sysseg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_tr,
  input  logic [15:0]   req_sel,
  input  logic [1:0]    req_cpl,
  input  logic          req_prot,
  input  logic [AW-1:0] gdt_base,
  input  logic [15:0]   gdt_limit,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic          done_o,
  output logic [4:0]    fault_vec_o,
  output logic [15:0]   fault_code_o,
  output logic          warn_o,
  output logic [15:0]   ldtr_sel_o,
  output logic [31:0]   ldtr_base_o,
  output logic [31:0]   ldtr_limit_o,
  output logic [15:0]   ldtr_attr_o,
  output logic          ldtr_valid_o,
  output logic [15:0]   tr_sel_o,
  output logic [31:0]   tr_base_o,
  output logic [31:0]   tr_limit_o,
  output logic [15:0]   tr_attr_o,
  output logic          tr_valid_o
);
  localparam int NREG    = 2;
  localparam int IDX_PAD = AW - 16;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_RD_LO, S_WT_LO, S_RD_HI, S_WT_HI, S_EVAL, S_WR
  } state_e;

  state_e        state, nxt;
  logic [15:0]   sel_q, tlim_q;
  logic [1:0]    cpl_q;
  logic          tr_q, prot_q;
  logic [AW-1:0] tbase_q, ent_addr;
  logic [31:0]   dlo_q, dhi_q;

  logic          type_ok, present, warn;
  logic [31:0]   d_base, d_limit;
  logic [15:0]   d_attr;
  logic [7:0]    busy_byte;

  logic          fin, fin_warn, do_load, do_clear;
  fault_vec_e    fin_vec;
  logic [15:0]   sel_err;
  logic          beyond;

  assign sel_err  = {sel_q[15:2], 2'b00};
  assign ent_addr = tbase_q + {{IDX_PAD{1'b0}}, sel_q[15:3], 3'b000};
  assign beyond   = {1'b0, sel_q[15:3], 3'b111} > {1'b0, tlim_q};

  sysseg_desc_check u_chk (
    .dlo(dlo_q), .dhi(dhi_q), .is_tr(tr_q),
    .type_ok(type_ok), .present(present), .base(d_base), .limit(d_limit),
    .attr(d_attr), .warn(warn), .busy_byte(busy_byte)
  );

  always_comb begin
    nxt      = state;
    fin      = 1'b0;
    fin_vec  = FV_NONE;
    fin_warn = 1'b0;
    do_load  = 1'b0;
    do_clear = 1'b0;
    unique case (state)
      S_IDLE:  if (req_valid) nxt = S_PRE;
      S_PRE: begin
        if (!prot_q)                  begin fin = 1'b1; fin_vec = FV_UD; end
        else if (cpl_q != 2'd0)       begin fin = 1'b1; fin_vec = FV_GP; end
        else if (sel_q[15:2] == '0)   begin fin = 1'b1; do_clear = 1'b1; end
        else if (!tr_q && sel_q[2])   begin fin = 1'b1; fin_vec = FV_GP; end
        else if (beyond)              begin fin = 1'b1; fin_vec = FV_GP; end
        else                          nxt = S_RD_LO;
      end
      S_RD_LO: if (mem_rd_ready)  nxt = S_WT_LO;
      S_WT_LO: if (mem_rsp_valid) nxt = S_RD_HI;
      S_RD_HI: if (mem_rd_ready)  nxt = S_WT_HI;
      S_WT_HI: if (mem_rsp_valid) nxt = S_EVAL;
      S_EVAL: begin
        if (!type_ok)      begin fin = 1'b1; fin_vec = FV_GP; end
        else if (!present) begin fin = 1'b1; fin_vec = FV_NP; end
        else if (tr_q)     nxt = S_WR;
        else begin fin = 1'b1; do_load = 1'b1; fin_warn = warn; end
      end
      S_WR: if (mem_wr_ready) begin fin = 1'b1; do_load = 1'b1; fin_warn = warn; end
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sel_q <= '0; tlim_q <= '0; cpl_q <= '0; tr_q <= 1'b0; prot_q <= 1'b0;
      tbase_q <= '0; dlo_q <= '0; dhi_q <= '0;
      done_o <= 1'b0; fault_vec_o <= FV_NONE; fault_code_o <= '0; warn_o <= 1'b0;
    end else begin
      state  <= nxt;
      done_o <= fin;
      if (state == S_IDLE && req_valid) begin
        sel_q <= req_sel; cpl_q <= req_cpl; tr_q <= req_tr; prot_q <= req_prot;
        tbase_q <= gdt_base; tlim_q <= gdt_limit;
      end
      if (state == S_WT_LO && mem_rsp_valid) dlo_q <= mem_rsp_data;
      if (state == S_WT_HI && mem_rsp_valid) dhi_q <= mem_rsp_data;
      if (fin) begin
        fault_vec_o  <= fin_vec;
        fault_code_o <= (fin_vec == FV_GP || fin_vec == FV_NP) &&
                        !(state == S_PRE && (cpl_q != 2'd0 || !prot_q)) ? sel_err : 16'h0000;
        warn_o       <= fin_warn;
      end
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_RD_LO) || (state == S_RD_HI);
  assign mem_rd_addr  = (state == S_RD_HI) ? ent_addr + AW'(4) : ent_addr;
  assign mem_wr_valid = (state == S_WR);
  assign mem_wr_addr  = ent_addr + AW'(5);
  assign mem_wr_data  = busy_byte;

  sysreg_t regs [NREG];
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    sysseg_reg #(.KEEP_SEL_ON_NULL(i == 0)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .load(do_load && (tr_q == (i == 1))),
      .clear(do_clear && (tr_q == (i == 1))),
      .sel(sel_q), .base(d_base), .limit(d_limit), .attr(d_attr),
      .q(regs[i])
    );
  end

  assign ldtr_sel_o = regs[0].sel;   assign ldtr_base_o = regs[0].base;
  assign ldtr_limit_o = regs[0].limit; assign ldtr_attr_o = regs[0].attr;
  assign ldtr_valid_o = regs[0].valid;
  assign tr_sel_o = regs[1].sel;     assign tr_base_o = regs[1].base;
  assign tr_limit_o = regs[1].limit; assign tr_attr_o = regs[1].attr;
  assign tr_valid_o = regs[1].valid;

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_wr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr));
  assert_real_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) && !prot_q |-> !mem_rd_valid && !mem_wr_valid);
  assert_busy_tr_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> tr_q && mem_wr_data[1]);
  assert_fault_keeps_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (fault_vec_o != FV_NONE) |-> $stable(ldtr_sel_o) && $stable(tr_sel_o)
      && $stable(ldtr_valid_o) && $stable(tr_valid_o) && $stable(tr_base_o));
  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready && fault_code_o[1:0] == 2'b00);
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/sim_sysseg_loader.sv
module sim_sysseg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_tr = 1'b0, req_prot = 1'b0;
  logic [15:0] req_sel = '0;
  logic [1:0] req_cpl = '0;
  logic req_ready;
  logic [31:0] gdt_base = 32'h80;
  logic [15:0] gdt_limit = 16'h3F;
  logic mem_rd_valid, mem_rd_ready, mem_rsp_valid, mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_rsp_data;
  logic [7:0] mem_wr_data;
  logic done_o, warn_o, ldtr_valid_o, tr_valid_o;
  logic [4:0] fault_vec_o;
  logic [15:0] fault_code_o, ldtr_sel_o, ldtr_attr_o, tr_sel_o, tr_attr_o;
  logic [31:0] ldtr_base_o, ldtr_limit_o, tr_base_o, tr_limit_o;

  logic bp_en = 1'b0, tick;
  int rd_count, wr_count;
  logic [7:0] mem [0:255];
  assign mem_rd_ready = !bp_en || tick;
  assign mem_wr_ready = !bp_en || tick;

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [4:0] t, input logic p, input logic g);
    return {b[31:24], g, 3'b000, l[19:16], p, 2'b00, t, b[23:16], b[15:0], l[15:0]};
  endfunction

  function automatic logic [63:0] desc_of(input int idx);
    case (idx)
      1: return mk(32'h00123456, 20'h000FF, 5'h02, 1'b1, 1'b0);
      2: return mk(32'h00002000, 20'h00067, 5'h09, 1'b1, 1'b0);
      3: return mk(32'h00003000, 20'h00014, 5'h01, 1'b1, 1'b0);
      4: return mk(32'h00004000, 20'h000FF, 5'h02, 1'b0, 1'b0);
      5: return mk(32'hAB000000, 20'h00003, 5'h02, 1'b1, 1'b1);
      6: return mk(32'h00006000, 20'h000FF, 5'h12, 1'b1, 1'b0);
      7: return mk(32'h00007000, 20'h00005, 5'h02, 1'b1, 1'b0);
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [7:0] init_byte(input int a);
    logic [63:0] d;
    if (a < 8'h80 || a >= 8'hC0) return 8'h00;
    d = desc_of((a - 8'h80) >> 3);
    return d[(a % 8) * 8 +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0; tick <= 1'b0;
      rd_count <= 0; wr_count <= 0;
    end else begin
      tick <= ~tick;
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {mem[mem_rd_addr[7:0] + 8'd3], mem[mem_rd_addr[7:0] + 8'd2],
                          mem[mem_rd_addr[7:0] + 8'd1], mem[mem_rd_addr[7:0]]};
        rd_count <= rd_count + 1;
      end
      if (mem_wr_valid && mem_wr_ready) begin
        mem[mem_wr_addr[7:0]] <= mem_wr_data;
        wr_count <= wr_count + 1;
      end
    end
  end

  sysseg_loader u0 (.*);

  int checks = 0, fails = 0;
  logic [4:0] r_vec; logic [15:0] r_code; logic r_warn; int r_reads;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic tr, input logic [15:0] sel, input logic [1:0] cpl, input logic prot);
    int r0;
    r0 = rd_count;
    @(negedge clk);
    req_valid = 1'b1; req_tr = tr; req_sel = sel; req_cpl = cpl; req_prot = prot;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_o) @(negedge clk);
    r_vec = fault_vec_o; r_code = fault_code_o; r_warn = warn_o;
    r_reads = rd_count - r0;
    @(negedge clk);
    chk("R13", "done pulse width", {63'b0, done_o}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", {63'b0, req_ready}, 64'd1);
    chk("R1", "done", {63'b0, done_o}, 64'd0);
    chk("R1", "valids", {62'b0, ldtr_valid_o, tr_valid_o}, 64'd0);
    chk("R1", "selectors", {32'b0, ldtr_sel_o, tr_sel_o}, 64'd0);
  endtask

  task automatic t_real_mode;
    do_load(1'b0, 16'h0008, 2'd3, 1'b0);
    chk("R2", "vector", r_vec, 6); chk("R2", "code", r_code, 0);
    chk("R2", "reads", r_reads, 0);
  endtask

  task automatic t_privilege;
    do_load(1'b1, 16'h0000, 2'd3, 1'b1);
    chk("R3", "vector", r_vec, 13); chk("R3", "code", r_code, 0);
  endtask

  task automatic t_ldt_ok;
    do_load(1'b0, 16'h0008, 2'd0, 1'b1);
    chk("R9", "vector", r_vec, 0); chk("R9", "valid", ldtr_valid_o, 1);
    chk("R9", "sel", ldtr_sel_o, 16'h0008); chk("R9", "base", ldtr_base_o, 32'h00123456);
    chk("R9", "limit", ldtr_limit_o, 32'hFF); chk("R9", "attr", ldtr_attr_o, 16'h0082);
    chk("R7", "two reads", r_reads, 2); chk("R12", "no warn", r_warn, 0);
  endtask

  task automatic t_gran;
    do_load(1'b0, 16'h002B, 2'd0, 1'b1);
    chk("R10", "limit", ldtr_limit_o, 32'h00003FFF);
    chk("R10", "base", ldtr_base_o, 32'hAB000000);
    chk("R9", "sel rpl kept", ldtr_sel_o, 16'h002B);
  endtask

  task automatic t_null;
    do_load(1'b0, 16'h0003, 2'd0, 1'b1);
    chk("R4", "ldt vector", r_vec, 0); chk("R4", "ldt valid", ldtr_valid_o, 0);
    chk("R4", "ldt sel kept", ldtr_sel_o, 16'h0003); chk("R4", "no reads", r_reads, 0);
    do_load(1'b1, 16'h0001, 2'd0, 1'b1);
    chk("R4", "tr valid", tr_valid_o, 0); chk("R4", "tr sel zero", tr_sel_o, 0);
  endtask

  task automatic t_ti;
    do_load(1'b0, 16'h000E, 2'd0, 1'b1);
    chk("R5", "vector", r_vec, 13); chk("R5", "code", r_code, 16'h000C);
  endtask

  task automatic t_bounds;
    do_load(1'b0, 16'h0041, 2'd0, 1'b1);
    chk("R6", "vector", r_vec, 13); chk("R6", "code", r_code, 16'h0040);
    chk("R6", "no reads", r_reads, 0);
    do_load(1'b0, 16'h0038, 2'd0, 1'b1);
    chk("R6", "last entry ok", r_vec, 0); chk("R6", "last base", ldtr_base_o, 32'h7000);
    chk("R12", "ldt warn", r_warn, 1);
  endtask

  task automatic t_types;
    do_load(1'b0, 16'h0031, 2'd0, 1'b1);
    chk("R7", "data seg vector", r_vec, 13); chk("R7", "data seg code", r_code, 16'h0030);
    do_load(1'b1, 16'h0008, 2'd0, 1'b1);
    chk("R7", "tr on ldt vector", r_vec, 13); chk("R7", "tr on ldt code", r_code, 16'h0008);
    do_load(1'b0, 16'h0022, 2'd0, 1'b1);
    chk("R8", "vector", r_vec, 11); chk("R8", "code", r_code, 16'h0020);
  endtask

  task automatic t_tss;
    bp_en = 1'b1;
    do_load(1'b1, 16'h0010, 2'd0, 1'b1);
    chk("R11", "vector", r_vec, 0); chk("R11", "busy byte", mem[8'h95], 8'h8B);
    chk("R9", "tr base", tr_base_o, 32'h2000); chk("R9", "tr limit", tr_limit_o, 32'h67);
    chk("R12", "tss32 no warn", r_warn, 0); chk("R13", "reads under bp", r_reads, 2);
    do_load(1'b1, 16'h0010, 2'd0, 1'b1);
    chk("R11", "busy reload vector", r_vec, 13); chk("R11", "busy reload code", r_code, 16'h0010);
    do_load(1'b1, 16'h0018, 2'd0, 1'b1);
    chk("R12", "tss16 warn", r_warn, 1); chk("R11", "tss16 busy byte", mem[8'h9D], 8'h83);
    chk("R9", "tr sel", tr_sel_o, 16'h0018);
    bp_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_real_mode;
    t_privilege;
    t_ldt_ok;
    t_gran;
    t_null;
    t_ti;
    t_bounds;
    t_types;
    t_tss;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule